// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches a bank of up to sixteen general-purpose input pins and turns chosen pin activity into one interrupt request. Each pin has its own trigger mode: falling edge, rising edge, both edges, high level or low level. Each pin has an enable bit that gates detection and a mask bit that only hides the pin from the combined request. Detected events latch in a status register. Software clears that register by writing ones.

The pins are asynchronous. Each one passes through a two-flop synchroniser before edge and level detection. Software reaches the state through a single-cycle register port. A write commits on the rising clock edge. A read is combinational from the address. Eight word addresses are decoded:

| Address | Access | Content |
|---|---|---|
| 0 | read/write | pin enable |
| 1 | read/write | pin mask |
| 2 | write | set mask bits written as 1 |
| 3 | write | clear mask bits written as 1 |
| 4 | read | status |
| 5 | write | clear status bits written as 1 |
| 6 | read/write | modes of pins 0 to 7 |
| 7 | read/write | modes of pins 8 to 15 |

Top module: `gpio_irq_detect`

## Requirements
- R1: The edge codes are 0 = falling edge, 1 = rising edge and 4 = both edges. In an edge mode a pin's status bit latches only on a matching transition of the synchronised input and stays set until it is cleared.
- R2: The level codes are 2 = low level and 3 = high level. In a level mode the status bit is set on every cycle in which the synchronised input matches, so a clear has no lasting effect while the level holds.
- R3: Pin n's 3-bit mode sits at bits [4(n mod 8)+2 : 4(n mod 8)]. Pins 0 to 7 use address 6 and pins 8 to 15 use address 7. Bit 4k+3 reads 0, and so do the slots of pins that are not implemented.
- R4: Writing address 5 clears every status bit written as 1. Bits written as 0 keep their value. If a new event arrives in the same cycle as the clear, the event wins.
- R5: Writing address 2 sets the mask bits written as 1, and writing address 3 clears the mask bits written as 1. Zero bits leave the mask unchanged. The mask reads back at address 1 and can be written directly there.
- R6: A pin whose enable bit (address 0) is 0 never latches status, whatever its input does.
- R7: The status register reads at address 4. Bits at and above NPINS read 0. Writes to address 4 have no effect. Unused bit positions of every register read 0.
- R8: The output `irq` is registered. It equals the OR over all pins of status AND enable AND NOT mask, as they stood in the previous cycle.
- R9: A masked pin still latches status. Masking only keeps the pin from raising `irq`.
- R10: After reset, every register reads 0 and `irq` is 0.
- R11: A change on a pin reaches its status bit on the third rising clock edge after the change, and reaches `irq` on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| pin_i | input | NPINS | asynchronous input pins |
| addr | input | 3 | register word address |
| wr_en | input | 1 | write strobe, commits on the rising edge |
| wdata | input | DW | write data |
| rdata | output | DW | read data for `addr`, combinational |
| irq | output | 1 | combined interrupt request |

## Verification
Each pin of a 12-pin instance is tried in all five trigger modes. The pin goes through the same sequence each time: held low, rising, held high, falling, with a status clear between phases. The resulting status and `irq` values separate the edge modes from each other, show that only the level modes re-latch after a clear, and show that each mode field reaches only its own pin. Separate patterns then do four things:
- clear and mask with mixed one/zero words, to show that zero bits do nothing;
- pulse disabled pins, and drive masked pins high, to tell gating apart from masking;
- drive every pin high at once, to show that the status bits above the pin count read zero;
- count the edges from a pin change to status and to `irq`.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  localparam logic [2:0] A_EN = 3'd0, A_MASK = 3'd1, A_MSET = 3'd2, A_MCLR = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4, A_CLR = 3'd5, A_MODE_LO = 3'd6, A_MODE_HI = 3'd7;
  localparam int SLOTS = 8;
  localparam int PITCH = 4;

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] en_q, mask_q, status_q;
  logic [NPINS-1:0] hit, clr;
  logic [NPINS-1:0][2:0] mode_q;

  assign clr = (wr_en && addr == A_CLR) ? wdata[NPINS-1:0] : '0;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      case (mode_q[p])
        3'd0:    hit[p] = prev[p] & ~sync2[p];
        3'd1:    hit[p] = ~prev[p] & sync2[p];
        3'd2:    hit[p] = ~sync2[p];
        3'd3:    hit[p] = sync2[p];
        3'd4:    hit[p] = prev[p] ^ sync2[p];
        default: hit[p] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      prev     <= '0;
      status_q <= '0;
      irq      <= 1'b0;
    end else begin
      sync1    <= pin_i;
      sync2    <= sync1;
      prev     <= sync2;
      status_q <= (status_q & ~clr) | (hit & en_q);
      irq      <= |(status_q & en_q & ~mask_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_EN:   en_q   <= wdata[NPINS-1:0];
        A_MASK: mask_q <= wdata[NPINS-1:0];
        A_MSET: mask_q <= mask_q | wdata[NPINS-1:0];
        A_MCLR: mask_q <= mask_q & ~wdata[NPINS-1:0];
        default: ;
      endcase
      for (int p = 0; p < NPINS; p++)
        if (addr == ((p < SLOTS) ? A_MODE_LO : A_MODE_HI))
          mode_q[p] <= wdata[PITCH*(p%SLOTS) +: 3];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN:   rdata[NPINS-1:0] = en_q;
      A_MASK: rdata[NPINS-1:0] = mask_q;
      A_STAT: rdata[NPINS-1:0] = status_q;
      A_MODE_LO, A_MODE_HI:
        for (int p = 0; p < NPINS; p++)
          if ((p < SLOTS) == (addr == A_MODE_LO))
            rdata[PITCH*(p%SLOTS) +: 3] = mode_q[p];
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       addr,
  input logic             wr_en,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic             irq,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] status_q
);
  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(status_q) & $past(en_q) & ~$past(mask_q)))); // R8

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd5) |=> (($past(status_q) & ~status_q) == '0)); // R4

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 3'd1 || addr == 3'd2 || addr == 3'd3)) |=> $stable(mask_q)); // R5

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> ((mask_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0]))); // R5

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0)); // R6

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd4) |-> ((rdata >> NPINS) == '0)); // R7
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .irq(irq), .en_q(en_q), .mask_q(mask_q), .status_q(status_q)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int N  = 12;
  localparam int DW = 32;
  localparam logic [DW-1:0] ALL = (1 << N) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [N-1:0] pins = '0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_irq_detect #(.NPINS(N), .DW(DW)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [DW-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(string req, int p, bit exp_bit);
    logic [DW-1:0] v;
    rd(3'd4, v);
    chk(req, v, exp_bit ? (DW'(1) << p) : '0);
    chk({req, " irq"}, DW'(irq), DW'(exp_bit));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    cyc(3); rst_n = 1; cyc(1);
    // R10 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R10", v, '0); end
    chk("R10 irq", DW'(irq), 0);

    // R3 mode field layout
    wr(3'd6, '1); rd(3'd6, v); chk("R3 lo", v, 32'h7777_7777);
    wr(3'd7, '1); rd(3'd7, v); chk("R3 hi", v, 32'h0000_7777);

    // per-pin, per-mode sweep: R1 R2 R3 R8
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [DW-1:0] mv;
        mv = DW'(m) << (4 * (p % 8));
        wr(3'd6, p < 8 ? mv : '0);
        wr(3'd7, p < 8 ? '0 : mv);
        rd(p < 8 ? 3'd6 : 3'd7, v); chk("R3 readback", v, mv);
        wr(3'd0, DW'(1) << p);
        cyc(4); wr(3'd5, ALL); cyc(2);
        step(m == 2 ? "R2 low held" : "R1 low held", p, m == 2);
        pins[p] = 1'b1; cyc(5);
        step(m >= 2 && m != 4 ? "R2 rise" : "R1 rise", p, m != 0);
        wr(3'd5, ALL); cyc(2);
        step("R2 clear while high", p, m == 3);
        pins[p] = 1'b0; cyc(5);
        step("R1 fall", p, m != 1);
        wr(3'd5, ALL); cyc(2);
        step("R2 clear while low", p, m == 2);
      end
    end

    // all pins rising-edge, all enabled
    wr(3'd6, 32'h1111_1111); wr(3'd7, 32'h0000_1111);
    wr(3'd0, ALL); wr(3'd5, ALL);
    // R11 latency
    @(negedge clk); pins = ALL;
    cyc(2); rd(3'd4, v); chk("R11 two edges", v, '0);
    cyc(1); rd(3'd4, v); chk("R11 three edges", v, ALL);
    chk("R11 irq not yet", DW'(irq), 0);
    cyc(1); chk("R11 irq four edges", DW'(irq), 1);
    // R7 upper bits and write to status ignored
    rd(3'd4, v); chk("R7 upper zero", v, ALL);
    wr(3'd4, '0); rd(3'd4, v); chk("R7 status write ignored", v, ALL);
    // R4 partial clear
    wr(3'd5, 32'h0F0); rd(3'd4, v); chk("R4 partial", v, ALL & ~32'h0F0);
    wr(3'd5, 32'h0); rd(3'd4, v); chk("R4 zeros", v, ALL & ~32'h0F0);
    // R5 mask set/clear
    wr(3'd2, 32'h00F); rd(3'd1, v); chk("R5 set", v, 32'h00F);
    wr(3'd2, 32'h0); rd(3'd1, v); chk("R5 set zeros", v, 32'h00F);
    wr(3'd3, 32'h003); rd(3'd1, v); chk("R5 clear", v, 32'h00C);
    wr(3'd3, 32'h0); rd(3'd1, v); chk("R5 clear zeros", v, 32'h00C);
    cyc(2); chk("R8 irq unmasked pending", DW'(irq), 1);
    // R9 mask all; status latches, irq stays low
    wr(3'd2, ALL); cyc(2); chk("R8 irq all masked", DW'(irq), 0);
    wr(3'd5, ALL); pins = '0; cyc(5); pins = ALL; cyc(5);
    rd(3'd4, v); chk("R9 latched while masked", v, ALL);
    chk("R9 irq masked", DW'(irq), 0);
    wr(3'd1, 32'h0); cyc(2); chk("R8 unmask raises irq", DW'(irq), 1);
    // R6 disabled pins never latch
    wr(3'd0, 32'h0); wr(3'd5, ALL);
    pins = '0; cyc(5); pins = ALL; cyc(5);
    rd(3'd4, v); chk("R6 disabled", v, '0);
    chk("R6 irq", DW'(irq), 0);
    wr(3'd0, 32'hA5A); rd(3'd0, v); chk("R6 enable readback", v, 32'hA5A);
    pins = '0; cyc(5); pins = ALL; cyc(5);
    rd(3'd4, v); chk("R6 partial enable", v, 32'hA5A);
    rd(3'd5, v); chk("R7 clear addr reads zero", v, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule